// File: doc/BRIEF.md
# SATA Receive Transport Deframer

This block sits on the receive side of a SATA host, between the link layer and the command layer. The link layer hands it 32-bit frame words one per cycle. Each word comes with start-of-frame and end-of-frame flags, and the last word of a frame also carries a CRC verdict. The block reads the type byte of the first word and sorts the frame into one of three classes: data, vendor-specific or other (control). It stores every word in a receive FIFO. It then raises a one-cycle arrival pulse when the frame's class rule is met.

A frame that is not yet acknowledged stays hidden from the command layer. If such a frame then ends with a bad CRC, its words are discarded by moving the write pointer back to the frame start. The command layer drains the FIFO through a valid/ready stream. When that stream is back-pressured, words pile up in the FIFO. Once occupancy exceeds a programmable threshold, a registered stall output tells the link layer to stop sending.

The link side has no ready input of its own: the stall output is its only back-pressure. The link layer must stop offering words while stall is high. It may send a few more words after stall rises, so the threshold must leave that many free entries.

Top module: `sata_rx_deframer`

## Requirements
- R1: The class comes from bits [7:0] of the start-of-frame word. 8'h46 is a data frame, 8'hC7 and 8'hD4 are vendor-specific, and every other value is a control frame. The arrival pulse carries that byte on `fis_type`.
- R2: A control frame is reported in the cycle after its end-of-frame word is accepted with `lnk_crc_ok` high.
- R3: A vendor-specific frame whose total length (header included) is at most `cfg_short_max` words is reported exactly like a control frame.
- R4: A vendor-specific frame that has grown beyond `cfg_short_max` words is reported in the cycle after a clock edge at which FIFO occupancy is at least `cfg_watermark`. If it ends before that happens, it follows the R2 rule.
- R5: A data frame is reported in the cycle after its header word is accepted, whatever its CRC turns out to be.
- R6: An end-of-frame word with `lnk_crc_ok` low gives a one-cycle `crc_err` in the next cycle. If the frame was not yet reported, it produces no arrival pulse and none of its words ever reach `cmd_data`.
- R7: Words of a frame that has not been reported are not offered to the command layer. Reported and completed words are offered in arrival order.
- R8: A word leaves the FIFO only on a cycle with `cmd_valid` and `cmd_ready` both high. While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` and `cmd_data` hold.
- R9: `lnk_stall` is high in exactly those cycles that follow a clock edge at which occupancy (hidden words included) exceeded `cfg_threshold`. It is low after reset.
- R10: `fis_rcvd` is a single-cycle pulse raised once per reported frame, and it is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_short_max | input | 16 | Longest vendor-specific frame, in words, that is still treated as short |
| cfg_watermark | input | 5 | Occupancy at which a long vendor-specific frame is reported |
| cfg_threshold | input | 5 | Occupancy above which stall is raised |
| lnk_valid | input | 1 | A word from the link layer is present this cycle |
| lnk_data | input | 32 | Frame word |
| lnk_sof | input | 1 | This word starts a frame |
| lnk_eof | input | 1 | This word ends a frame |
| lnk_crc_ok | input | 1 | CRC verdict, meaningful with lnk_eof |
| lnk_stall | output | 1 | Stall request to the link layer |
| cmd_valid | output | 1 | A stored word is offered to the command layer |
| cmd_data | output | 32 | Offered word |
| cmd_ready | input | 1 | Command layer accepts the offered word |
| fis_rcvd | output | 1 | One-cycle frame arrival pulse |
| fis_type | output | 8 | Type byte of the reported frame, valid with fis_rcvd |
| crc_err | output | 1 | One-cycle bad-CRC pulse |

## Verification
The hardest case to reach is a long vendor-specific frame crossing the watermark in the middle of the frame. That only happens if the FIFO already holds enough words while the frame is still hidden. The stimulus therefore holds `cmd_ready` low, sets a small short limit and a watermark below the frame length, and checks that the pulse arrives before the end of the frame. A companion case uses a watermark the frame never reaches and expects the report at end-of-frame instead. Stall is forced by toggling `cmd_ready` during a long data frame with a low threshold, so the link driver has to pause. A per-cycle queue model tracks the hidden tail and the rewind on a bad CRC.

// File: rtl/sata_rx_pkg.sv
package sata_rx_pkg;

  typedef enum logic [1:0] {
    FIS_CTRL   = 2'd0,
    FIS_DATA   = 2'd1,
    FIS_VENDOR = 2'd2
  } fis_class_e;

  localparam logic [7:0] TYPE_DATA    = 8'h46;
  localparam logic [7:0] TYPE_VENDOR0 = 8'hC7;
  localparam logic [7:0] TYPE_VENDOR1 = 8'hD4;

  function automatic fis_class_e classify(input logic [7:0] tbyte);
    if (tbyte == TYPE_DATA)
      return FIS_DATA;
    else if (tbyte == TYPE_VENDOR0 || tbyte == TYPE_VENDOR1)
      return FIS_VENDOR;
    else
      return FIS_CTRL;
  endfunction

endpackage

// File: rtl/sata_rx_fifo.sv
// Receive FIFO with a hidden tail (the words of a frame not yet reported)
// and a rewind that drops that tail. DEPTH must be a power of two.
module sata_rx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_mark,
  input  logic          rewind,
  input  logic          hide,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          rd_ready,
  output logic [AW:0]   level,
  input  logic [AW:0]   stall_thr,
  output logic          stall
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr, start_ptr;
  logic [AW:0]   vis_ptr;
  logic          pop;

  assign level    = wr_ptr - rd_ptr;
  assign vis_ptr  = hide ? start_ptr : wr_ptr;
  assign rd_valid = (rd_ptr != vis_ptr);
  assign rd_data  = mem[rd_ptr[AW-1:0]];
  assign pop      = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      start_ptr <= '0;
      stall     <= 1'b0;
    end else begin
      stall <= (level > stall_thr);
      if (wr_en && wr_mark) start_ptr <= wr_ptr;
      if (rewind)
        wr_ptr <= wr_mark ? wr_ptr : start_ptr;
      else if (wr_en)
        wr_ptr <= wr_ptr + 1'b1;
      if (pop) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  // R9: the link layer honours stall, so no word arrives into a full FIFO
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> level < (AW+1)'(DEPTH));

  // R8: an offered word that is not taken stays offered and unchanged
  a_r8_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R6: a rewind never leaves the FIFO fuller than before
  a_r6_rewind_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> level <= $past(level));

endmodule

// File: rtl/sata_rx_fis_tracker.sv
// Per-frame state: class, length, reported flag, and the arrival and error rules.
module sata_rx_fis_tracker
  import sata_rx_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          sof,
  input  logic          eof,
  input  logic          crc_ok,
  input  logic [7:0]    type_byte,
  input  logic [AW:0]   level,
  input  logic [CW-1:0] cfg_short_max,
  input  logic [AW:0]   cfg_watermark,
  output logic          hide,
  output logic          rewind,
  output logic          fis_rcvd,
  output logic [7:0]    fis_type,
  output logic          crc_err
);

  fis_class_e    cls_q, cls_n, dec;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          in_q, in_n, rep_q, rep_n;
  logic [7:0]    typ_q, typ_n, rtype;
  logic          report, err, wm_hit;

  assign dec    = classify(type_byte);
  assign wm_hit = in_q && (cls_q == FIS_VENDOR) && (cnt_q > cfg_short_max) &&
                  !rep_q && (level >= cfg_watermark);
  assign hide   = in_q && !rep_q;

  always_comb begin
    report = 1'b0;
    err    = 1'b0;
    rewind = 1'b0;
    rtype  = typ_q;
    rep_n  = rep_q;
    in_n   = in_q;
    cnt_n  = cnt_q;
    cls_n  = cls_q;
    typ_n  = typ_q;
    if (wr_en) begin
      if (sof) begin
        typ_n = type_byte;
        cls_n = dec;
        cnt_n = CW'(1);
        in_n  = 1'b1;
        rep_n = 1'b0;
        rtype = type_byte;
        if (dec == FIS_DATA) begin
          report = 1'b1;
          rep_n  = 1'b1;
        end
      end else if (cnt_q != '1) begin
        cnt_n = cnt_q + 1'b1;
      end
      if (eof) begin
        in_n = 1'b0;
        if (!rep_n) begin
          if (crc_ok) begin
            report = 1'b1;
            rep_n  = 1'b1;
          end else begin
            err    = 1'b1;
            rewind = 1'b1;
          end
        end else if (!crc_ok) begin
          err = 1'b1;
        end
      end
    end
    if (!(wr_en && (sof || eof)) && wm_hit) begin
      report = 1'b1;
      rep_n  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cls_q    <= FIS_CTRL;
      cnt_q    <= '0;
      in_q     <= 1'b0;
      rep_q    <= 1'b0;
      typ_q    <= '0;
      fis_rcvd <= 1'b0;
      fis_type <= '0;
      crc_err  <= 1'b0;
    end else begin
      cls_q    <= cls_n;
      cnt_q    <= cnt_n;
      in_q     <= in_n;
      rep_q    <= rep_n;
      typ_q    <= typ_n;
      fis_rcvd <= report;
      fis_type <= report ? rtype : fis_type;
      crc_err  <= err;
    end
  end

  // R5: a data header word is reported on the next cycle
  a_r5_data_on_header: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && sof && type_byte == TYPE_DATA |=> fis_rcvd && fis_type == TYPE_DATA);

  // R6: a bad CRC at end-of-frame always yields an error pulse
  a_r6_bad_crc_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && eof && !crc_ok |=> crc_err);

  // R10: an arrival pulse is always preceded by an accepted word or a watermark hit
  a_r10_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fis_rcvd) |-> $past(wr_en || wm_hit));

endmodule

// File: rtl/sata_rx_deframer.sv
module sata_rx_deframer #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int CW    = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CW-1:0]          cfg_short_max,
  input  logic [$clog2(DEPTH):0] cfg_watermark,
  input  logic [$clog2(DEPTH):0] cfg_threshold,
  input  logic                   lnk_valid,
  input  logic [DW-1:0]          lnk_data,
  input  logic                   lnk_sof,
  input  logic                   lnk_eof,
  input  logic                   lnk_crc_ok,
  output logic                   lnk_stall,
  output logic                   cmd_valid,
  output logic [DW-1:0]          cmd_data,
  input  logic                   cmd_ready,
  output logic                   fis_rcvd,
  output logic [7:0]             fis_type,
  output logic                   crc_err
);

  localparam int AW = $clog2(DEPTH);

  logic [AW:0] level;
  logic        hide, rewind;

  sata_rx_fis_tracker #(.CW(CW), .AW(AW)) u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (lnk_valid),
    .sof           (lnk_sof),
    .eof           (lnk_eof),
    .crc_ok        (lnk_crc_ok),
    .type_byte     (lnk_data[7:0]),
    .level         (level),
    .cfg_short_max (cfg_short_max),
    .cfg_watermark (cfg_watermark),
    .hide          (hide),
    .rewind        (rewind),
    .fis_rcvd      (fis_rcvd),
    .fis_type      (fis_type),
    .crc_err       (crc_err)
  );

  sata_rx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (lnk_valid),
    .wr_data   (lnk_data),
    .wr_mark   (lnk_sof),
    .rewind    (rewind),
    .hide      (hide),
    .rd_valid  (cmd_valid),
    .rd_data   (cmd_data),
    .rd_ready  (cmd_ready),
    .level     (level),
    .stall_thr (cfg_threshold),
    .stall     (lnk_stall)
  );

  // R9: stall only follows an edge where occupancy was above the threshold
  a_r9_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_stall |-> $past(level) > $past(cfg_threshold));

endmodule

// File: tb/test_sata_rx_deframer.sv
module test_sata_rx_deframer;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_short_max = 16'd3;
  logic [4:0]  cfg_watermark = 5'd6;
  logic [4:0]  cfg_threshold = 5'd12;
  logic        lnk_valid = 1'b0, lnk_sof = 1'b0, lnk_eof = 1'b0, lnk_crc_ok = 1'b0;
  logic [31:0] lnk_data = '0;
  logic        lnk_stall, cmd_valid, cmd_ready, fis_rcvd, crc_err;
  logic [31:0] cmd_data;
  logic [7:0]  fis_type;

  always #(CLK_PERIOD/2) clk = ~clk;

  sata_rx_deframer i_sata_rx_deframer (
    .clk(clk), .rst_n(rst_n), .cfg_short_max(cfg_short_max),
    .cfg_watermark(cfg_watermark), .cfg_threshold(cfg_threshold),
    .lnk_valid(lnk_valid), .lnk_data(lnk_data), .lnk_sof(lnk_sof),
    .lnk_eof(lnk_eof), .lnk_crc_ok(lnk_crc_ok), .lnk_stall(lnk_stall),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
    .fis_rcvd(fis_rcvd), .fis_type(fis_type), .crc_err(crc_err)
  );

  int checks = 0, failures = 0;
  int n_rcv = 0, n_err = 0, n_stall = 0;
  int rdy_mode = 0;
  bit tog = 1'b0;

  // reference model state
  logic [31:0] mq[$];
  int  pend = 0, cnt = 0, cls = 0;
  bit  in_fr = 0, rep = 0;
  logic [7:0] typ = '0;
  bit  e_rcv = 0, e_err = 0, e_stall = 0;
  logic [7:0] e_type = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int class_of(input logic [7:0] b);
    if (b == 8'h46) return 1;
    if (b == 8'hC7 || b == 8'hD4) return 2;
    return 0;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) cmd_ready = 1'b0;
    else begin
      tog = ~tog;
      cmd_ready = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? tog : 1'b0;
    end
  end

  // behavioural model, updated on every edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); pend = 0; cnt = 0; cls = 0; in_fr = 0; rep = 0; typ = '0;
      e_rcv = 0; e_err = 0; e_stall = 0; e_type = '0;
    end else begin
      int  lvl;
      bit  wm, popit, ev, er;
      logic [7:0] et;
      lvl   = mq.size();
      wm    = in_fr && cls == 2 && cnt > int'(cfg_short_max) && !rep &&
              lvl >= int'(cfg_watermark);
      popit = (mq.size() > pend) && cmd_ready;
      ev = 0; er = 0; et = typ;
      if (lnk_valid) begin
        if (lnk_sof) begin
          typ = lnk_data[7:0]; cls = class_of(typ); cnt = 1; rep = 0;
          pend = 0; in_fr = 1; et = typ;
          if (cls == 1) begin rep = 1; ev = 1; end
        end else if (cnt < 65535) cnt++;
        mq.push_back(lnk_data);
        if (!rep) pend++;
        if (lnk_eof) begin
          in_fr = 0;
          if (!rep) begin
            if (lnk_crc_ok) begin ev = 1; rep = 1; pend = 0; end
            else begin
              er = 1;
              repeat (pend) void'(mq.pop_back());
              pend = 0;
            end
          end else if (!lnk_crc_ok) er = 1;
        end
      end
      if (!(lnk_valid && (lnk_sof || lnk_eof)) && wm) begin
        ev = 1; rep = 1; pend = 0; et = typ;
      end
      if (popit) void'(mq.pop_front());
      e_stall = lvl > int'(cfg_threshold);
      e_rcv = ev; e_err = er;
      if (ev) e_type = et;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit ev_exp;
      ev_exp = mq.size() > pend;
      check(lnk_stall === e_stall, "R9", "lnk_stall", 32'(lnk_stall), 32'(e_stall));
      check(cmd_valid === ev_exp, "R7", "cmd_valid", 32'(cmd_valid), 32'(ev_exp));
      if (ev_exp)
        check(cmd_data === mq[0], "R8", "cmd_data", cmd_data, mq[0]);
      check(fis_rcvd === e_rcv, "R10", "fis_rcvd", 32'(fis_rcvd), 32'(e_rcv));
      if (e_rcv)
        check(fis_type === e_type, "R1", "fis_type", 32'(fis_type), 32'(e_type));
      check(crc_err === e_err, "R6", "crc_err", 32'(crc_err), 32'(e_err));
      if (fis_rcvd) n_rcv++;
      if (crc_err) n_err++;
      if (lnk_stall) n_stall++;
    end
  end

  task automatic send(input logic [7:0] t, input int n, input bit ok, input int tagv);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (lnk_stall) begin
        lnk_valid = 1'b0;
        @(negedge clk);
      end
      lnk_valid  = 1'b1;
      lnk_sof    = (i == 0);
      lnk_eof    = (i == n - 1);
      lnk_crc_ok = ok;
      lnk_data   = {8'(tagv), 8'(i), 8'(i * 7 + 1), (i == 0) ? t : 8'(i * 3 + 5)};
    end
    @(negedge clk);
    lnk_valid = 1'b0; lnk_sof = 1'b0; lnk_eof = 1'b0;
  endtask

  task automatic drain();
    rdy_mode = 1;
    repeat (40) @(negedge clk);
  endtask

  task automatic run_all();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(lnk_stall === 1'b0, "R9", "stall after reset", 32'(lnk_stall), 0);
    check(cmd_valid === 1'b0, "R7", "valid after reset", 32'(cmd_valid), 0);
    check(fis_rcvd === 1'b0, "R10", "pulse after reset", 32'(fis_rcvd), 0);

    // R2: control frame, good CRC, command layer always ready
    n_rcv = 0; n_err = 0; rdy_mode = 1;
    send(8'h34, 5, 1'b1, 1); drain();
    check(n_rcv == 1, "R2", "control frame reports", n_rcv, 1);

    // R6: control frame, bad CRC, words discarded
    n_rcv = 0; n_err = 0;
    send(8'h27, 4, 1'b0, 2); drain();
    check(n_rcv == 0 && n_err == 1, "R6", "bad control rcv/err", n_rcv * 16 + n_err, 1);

    // R3: short vendor frame behaves like control
    n_rcv = 0; n_err = 0; rdy_mode = 0;
    send(8'hC7, 3, 1'b1, 3); drain();
    check(n_rcv == 1, "R3", "short vendor reports", n_rcv, 1);
    n_rcv = 0; n_err = 0;
    send(8'hD4, 2, 1'b0, 4); drain();
    check(n_rcv == 0 && n_err == 1, "R3", "short vendor bad CRC", n_rcv * 16 + n_err, 1);

    // R4: long vendor frame crosses the watermark mid-frame
    n_rcv = 0; n_err = 0; rdy_mode = 0;
    send(8'hC7, 10, 1'b1, 5); drain();
    check(n_rcv == 1, "R4", "long vendor reports once", n_rcv, 1);

    // R4: long vendor frame ending below the watermark
    n_rcv = 0; n_err = 0; rdy_mode = 0; cfg_watermark = 5'd15;
    send(8'hD4, 6, 1'b1, 6); drain();
    check(n_rcv == 1, "R4", "long vendor reports at end", n_rcv, 1);
    cfg_watermark = 5'd6;

    // R5 and R9: long data frame against a slow reader and a low threshold
    n_rcv = 0; n_err = 0; n_stall = 0; rdy_mode = 2; cfg_threshold = 5'd6;
    send(8'h46, 24, 1'b1, 7); drain();
    check(n_rcv == 1, "R5", "data frame reports", n_rcv, 1);
    check(n_stall > 0, "R9", "stall raised", n_stall, 1);
    cfg_threshold = 5'd12;

    // R5 and R6: one-word data frame with bad CRC gives both pulses
    n_rcv = 0; n_err = 0;
    send(8'h46, 1, 1'b0, 8); drain();
    check(n_rcv == 1 && n_err == 1, "R5", "data bad CRC", n_rcv * 16 + n_err, 17);

    // R1 and R7: back-to-back frames of mixed classes with toggling ready
    n_rcv = 0; n_err = 0; rdy_mode = 2;
    send(8'h5F, 3, 1'b1, 9);
    send(8'h46, 4, 1'b1, 10);
    send(8'hA1, 2, 1'b0, 11);
    send(8'hC7, 1, 1'b1, 12);
    drain();
    check(n_rcv == 3 && n_err == 1, "R1", "mixed frames", n_rcv * 16 + n_err, 49);

    // R8: everything drained in the end
    @(negedge clk);
    check(cmd_valid === 1'b0, "R8", "fifo empty after drain", 32'(cmd_valid), 0);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      run_all();
      begin
        repeat (WATCHDOG) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule